// File: doc/BRIEF.md
# EEPROM Page Buffer with Timed Write Cycle

This block sits between a serial-bus slave controller and the storage array of a small byte-addressed non-volatile memory. The controller hands it a 10-bit starting address once the memory address word of a write transaction has been received. It then passes each data byte as a one-cycle strobe. The block gathers those bytes in a page-sized latch. Only the low slot bits of the address advance, so a long burst wraps and overwrites the earlier bytes of the same page.

When the controller reports a stop condition and at least one byte was latched, the block raises `busy_o`. It drains the loaded slots into the array write port one per clock, lowest slot first. It then holds `busy_o` for a programmable number of system clocks that models the internal programming time. While `busy_o` is high, the controller is expected to refuse its device address word. That refusal is what makes acknowledge polling work. The block itself ignores every input during that time.

With the write-protect input high, data bytes are discarded, and a stop with nothing latched never starts a cycle. The dummy write that opens a random read is the same case. `cur_addr_o` always shows the address the next access will use.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low and `cur_addr_o` is 0.
- R2: A `start_i` pulse while idle loads `start_addr_i` into `cur_addr_o` on the next cycle and discards any bytes latched before it; `start_i` takes priority over `stop_i` and `byte_vld_i` in the same cycle.
- R3: Each accepted data byte increments only the low 4 bits (slot) of `cur_addr_o`; the upper 6 bits (page) never change, and slot 15 wraps to slot 0.
- R4: A byte sent to a slot that already holds a byte in the same transaction replaces it; only the last value is written to the array.
- R5: A stop with at least one latched byte raises `busy_o` on the next cycle and, beginning in that cycle, asserts `mem_we_o` once per loaded slot on consecutive cycles in ascending slot order, with `mem_addr_o` = {page, slot} and `mem_wdata_o` the latched byte; unloaded slots are never written.
- R6: `busy_o` stays high for exactly N + WC_CYCLES cycles, where N is the number of loaded slots.
- R7: While `busy_o` is high, `start_i`, `byte_vld_i` and `stop_i` have no effect: `cur_addr_o` holds, no byte is latched and no second cycle is queued.
- R8: While `wp_i` is high, data bytes are neither latched nor counted in `cur_addr_o`, so a following stop starts no write cycle.
- R9: A stop with no latched byte leaves `busy_o` low and produces no array write.
- R10: After a write, `cur_addr_o` is the slot after the last byte received, wrapped inside its page, including at the top address of the array.
- R11: `mem_we_o` is asserted only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load starting address, open a new write transaction |
| start_addr_i | input | 10 | Starting byte address |
| byte_vld_i | input | 1 | One-cycle strobe of a received data byte |
| byte_i | input | 8 | Received data byte |
| stop_i | input | 1 | One-cycle stop condition pulse |
| wp_i | input | 1 | Write protect, high blocks byte latching |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 10 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| cur_addr_o | output | 10 | Current address for the next access |

## Verification
The bound checker watches every cycle for the properties that involve only local relations. Array writes must fall inside the current page, in rising slot order, and only while busy. Each accepted byte must step the address inside its page. The address must hold while busy or while write protect is high. Every busy period must open with a stop and a write. The directed scenarios are the only way to show what needs a whole transaction: which values reach the array after a wrapped or overwritten burst, the exact busy length, and that bytes strobed during a cycle or under write protect leave nothing for a later stop to commit.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COMMIT,
    ST_TIMING
  } cyc_state_e;
endpackage

// File: rtl/pgbuf_latch.sv
module pgbuf_latch #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                clr_all_i,
  input  logic                                ld_en_i,
  input  logic [SLOT_W-1:0]                   ld_slot_i,
  input  logic [DATA_W-1:0]                   ld_data_i,
  input  logic                                clr_en_i,
  input  logic [SLOT_W-1:0]                   clr_slot_i,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]   page_data_o,
  output logic [PAGE_BYTES-1:0]               mask_o
);

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit_ld, hit_clr;
    assign hit_ld  = ld_en_i  && (ld_slot_i  == SLOT_W'(g));
    assign hit_clr = clr_en_i && (clr_slot_i == SLOT_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[g] <= 1'b0;
      end else if (clr_all_i || hit_clr) begin
        mask_o[g] <= 1'b0;
      end else if (hit_ld) begin
        mask_o[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_data_o[g] <= '0;
      end else if (hit_ld) begin
        page_data_o[g] <= ld_data_i;
      end
    end
  end

endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
  parameter int WC_CYCLES = 500000,
  localparam int CNT_W    = $clog2(WC_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(WC_CYCLES - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int WC_CYCLES  = 500000,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - SLOT_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              go_i,
  input  logic [PAGE_W-1:0]                 page_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data_i,
  output logic                              clr_en_o,
  output logic [SLOT_W-1:0]                 clr_slot_o,
  output logic                              busy_o,
  output logic                              mem_we_o,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  output logic [DATA_W-1:0]                 mem_wdata_o
);

  cyc_state_e          state_q, state_d;
  logic [SLOT_W-1:0]   sel;
  logic [PAGE_BYTES-1:0] sel_oh;
  logic                last_one;
  logic                tmr_load, tmr_done;

  // lowest loaded slot drains first
  always_comb begin
    sel = '0;
    for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
      if (mask_i[i]) sel = SLOT_W'(i);
    end
  end

  assign sel_oh   = PAGE_BYTES'(1) << sel;
  assign last_one = ((mask_i & ~sel_oh) == '0);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (go_i) state_d = ST_COMMIT;
      ST_COMMIT: if (last_one) begin
                   state_d  = ST_TIMING;
                   tmr_load = 1'b1;
                 end
      ST_TIMING: if (tmr_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  pgbuf_timer #(.WC_CYCLES(WC_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .done_o (tmr_done)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_we_o    = (state_q == ST_COMMIT) && (mask_i != '0);
  assign mem_addr_o  = {page_i, sel};
  assign mem_wdata_o = page_data_i[sel];
  assign clr_en_o    = mem_we_o;
  assign clr_slot_o  = sel;

endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top #(
  parameter int ADDR_W     = 10,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int WC_CYCLES  = 500000,
  localparam int SLOT_W    = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] cur_addr_o
);

  logic [ADDR_W-1:0]                 addr_q;
  logic                              start_acc, stop_acc, byte_acc, go;
  logic [PAGE_BYTES-1:0]             mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] page_data;
  logic                              clr_en;
  logic [SLOT_W-1:0]                 clr_slot;

  // priority: start > stop > byte; all ignored while busy
  assign start_acc = start_i & ~busy_o;
  assign stop_acc  = stop_i & ~busy_o & ~start_i;
  assign byte_acc  = byte_vld_i & ~busy_o & ~wp_i & ~start_i & ~stop_i;
  assign go        = stop_acc & (mask != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (start_acc) begin
      addr_q <= start_addr_i;
    end else if (byte_acc) begin
      addr_q[SLOT_W-1:0] <= addr_q[SLOT_W-1:0] + 1'b1;
    end
  end

  pgbuf_latch #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W)
  ) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_all_i   (start_acc),
    .ld_en_i     (byte_acc),
    .ld_slot_i   (addr_q[SLOT_W-1:0]),
    .ld_data_i   (byte_i),
    .clr_en_i    (clr_en),
    .clr_slot_i  (clr_slot),
    .page_data_o (page_data),
    .mask_o      (mask)
  );

  pgbuf_commit #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .WC_CYCLES  (WC_CYCLES)
  ) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .page_i      (addr_q[ADDR_W-1:SLOT_W]),
    .mask_i      (mask),
    .page_data_i (page_data),
    .clr_en_o    (clr_en),
    .clr_slot_o  (clr_slot),
    .busy_o      (busy_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign cur_addr_o = addr_q;

endmodule

// File: rtl/pgbuf_checker.sv
module pgbuf_checker #(
  parameter int ADDR_W = 10,
  parameter int SLOT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              byte_vld_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] cur_addr_o
);

  a_r11_we_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  a_r5_we_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[ADDR_W-1:SLOT_W] == cur_addr_o[ADDR_W-1:SLOT_W]);

  a_r5_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |->
      mem_addr_o[SLOT_W-1:0] > $past(mem_addr_o[SLOT_W-1:0]));

  a_r5_first_busy_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_we_o);

  a_r9_busy_needs_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));

  a_r7_addr_hold_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_addr_o));

  a_r8_wp_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && !start_i && !busy_o) |=> $stable(cur_addr_o));

  a_r3_in_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && !busy_o && !wp_i && !start_i && !stop_i) |=>
      (cur_addr_o[ADDR_W-1:SLOT_W] == $past(cur_addr_o[ADDR_W-1:SLOT_W])) &&
      (cur_addr_o[SLOT_W-1:0] == SLOT_W'($past(cur_addr_o[SLOT_W-1:0]) + 1'b1)));

endmodule

bind pgbuf_top pgbuf_checker #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .byte_vld_i (byte_vld_i),
  .stop_i     (stop_i),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .cur_addr_o (cur_addr_o)
);

// File: tb/pgbuf_top_bench.sv
module pgbuf_top_bench;
  localparam int WC = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_addr_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic       stop_i = 1'b0;
  logic       wp_i = 1'b0;
  logic       busy_o, mem_we_o;
  logic [9:0] mem_addr_o, cur_addr_o;
  logic [7:0] mem_wdata_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [9:0] wa [64];
  logic [7:0] wd [64];
  int         wn = 0;

  always #5 clk = ~clk;

  pgbuf_top #(.WC_CYCLES(WC)) u_pgbuf_top (
    .clk_i (clk), .rst_ni (rst_n),
    .start_i (start_i), .start_addr_i (start_addr_i),
    .byte_vld_i (byte_vld_i), .byte_i (byte_i),
    .stop_i (stop_i), .wp_i (wp_i),
    .busy_o (busy_o), .mem_we_o (mem_we_o),
    .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
    .cur_addr_o (cur_addr_o)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we_o && wn < 64) begin
      wa[wn] = mem_addr_o;
      wd[wn] = mem_wdata_o;
      wn++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [9:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    byte_vld_i = 1'b1; byte_i = d;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic stop_count(output int n);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    n = 0;
    while (busy_o && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(mem_we_o == 1'b0, "R1 we", mem_we_o, 0);
    chk(cur_addr_o == 10'h000, "R1 addr", cur_addr_o, 0);
  endtask

  task automatic t_byte_write;
    int n;
    wn = 0;
    do_start(10'h123);
    chk(cur_addr_o == 10'h123, "R2 load", cur_addr_o, 10'h123);
    send(8'hA5);
    chk(cur_addr_o == 10'h124, "R3 step", cur_addr_o, 10'h124);
    stop_count(n);
    chk(n == 1 + WC, "R6 busy len", n, 1 + WC);
    chk(wn == 1, "R5 count", wn, 1);
    chk(wa[0] == 10'h123 && wd[0] == 8'hA5, "R5 byte", {wa[0], wd[0]}, {10'h123, 8'hA5});
    chk(cur_addr_o == 10'h124, "R10 after", cur_addr_o, 10'h124);
  endtask

  task automatic t_wrap;
    int n;
    logic [9:0] ea [5] = '{10'h2F0, 10'h2F1, 10'h2FD, 10'h2FE, 10'h2FF};
    logic [7:0] ed [5] = '{8'h44, 8'h55, 8'h11, 8'h22, 8'h33};
    wn = 0;
    do_start(10'h2FD);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'h55);
    chk(cur_addr_o == 10'h2F2, "R3 wrap", cur_addr_o, 10'h2F2);
    stop_count(n);
    chk(n == 5 + WC, "R6 busy len", n, 5 + WC);
    chk(wn == 5, "R5 count", wn, 5);
    for (int i = 0; i < 5; i++)
      chk(wa[i] == ea[i] && wd[i] == ed[i], "R5 order", {wa[i], wd[i]}, {ea[i], ed[i]});
  endtask

  task automatic t_overwrite;
    int n;
    bit ok;
    wn = 0;
    do_start(10'h040);
    for (int i = 0; i < 18; i++) send(8'(8'h80 + i));
    stop_count(n);
    chk(n == 16 + WC, "R6 busy len", n, 16 + WC);
    chk(wn == 16, "R4 count", wn, 16);
    ok = 1'b1;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] e;
      e = (k < 2) ? 8'(8'h90 + k) : 8'(8'h80 + k);
      if (wa[k] != 10'(10'h040 + k) || wd[k] != e) ok = 1'b0;
    end
    chk(ok, "R4 replace", wd[0], 8'h90);
    chk(cur_addr_o == 10'h042, "R10 after", cur_addr_o, 10'h042);
  endtask

  task automatic t_wp;
    int n;
    wn = 0;
    do_start(10'h100);
    wp_i = 1'b1;
    send(8'h5A); send(8'h6B);
    chk(cur_addr_o == 10'h100, "R8 addr", cur_addr_o, 10'h100);
    stop_count(n);
    wp_i = 1'b0;
    chk(n == 0, "R8 no busy", n, 0);
    chk(wn == 0, "R8 no write", wn, 0);
  endtask

  task automatic t_empty_stop;
    int n;
    wn = 0;
    do_start(10'h3A0);
    stop_count(n);
    repeat (3) @(negedge clk);
    chk(n == 0, "R9 no busy", n, 0);
    chk(wn == 0, "R9 no write", wn, 0);
    chk(cur_addr_o == 10'h3A0, "R9 addr", cur_addr_o, 10'h3A0);
  endtask

  task automatic t_busy_ignore;
    int n;
    wn = 0;
    do_start(10'h010);
    send(8'h77);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(busy_o == 1'b1, "R5 busy rise", busy_o, 1);
    do_start(10'h200);
    send(8'hEE);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk(cur_addr_o == 10'h011, "R7 addr hold", cur_addr_o, 10'h011);
    n = 0;
    while (busy_o && n < 2000) begin n++; @(negedge clk); end
    chk(wn == 1 && wa[0] == 10'h010 && wd[0] == 8'h77, "R7 one write", wn, 1);
    stop_count(n);
    chk(n == 0, "R7 nothing latched", n, 0);
    chk(cur_addr_o == 10'h011, "R7 addr", cur_addr_o, 10'h011);
  endtask

  task automatic t_top_addr;
    int n;
    wn = 0;
    do_start(10'h3FF);
    send(8'hC3);
    stop_count(n);
    chk(wn == 1 && wa[0] == 10'h3FF && wd[0] == 8'hC3, "R5 top byte", wa[0], 10'h3FF);
    chk(cur_addr_o == 10'h3F0, "R10 top wrap", cur_addr_o, 10'h3F0);
  endtask

  task automatic t_start_prio;
    int n;
    wn = 0;
    do_start(10'h080);
    send(8'h01);
    start_i = 1'b1; start_addr_i = 10'h090; stop_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h02;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0; byte_vld_i = 1'b0;
    chk(busy_o == 1'b0 && cur_addr_o == 10'h090, "R2 priority", cur_addr_o, 10'h090);
    stop_count(n);
    chk(n == 0 && wn == 0, "R2 discard", wn, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_write();
    t_wrap();
    t_overwrite();
    t_wp();
    t_empty_stop();
    t_busy_ignore();
    t_top_addr();
    t_start_prio();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule